// File: doc/BRIEF.md
# Direct-Mapped Translation Fast-Path Lookup

This block resolves a linear address to a host address for a direct data access, using a small direct-mapped translation buffer. A requester presents a linear address, the access length in bytes, its privilege level (0 to 3) and whether it reads or writes. One cycle later the block reports whether the access may bypass the slow path. On a hit it returns the host address, made from the entry's host page base and the in-page offset. A hit that writes also raises a strobe carrying the entry's physical page frame, so that decoded code cached from that page can be retired.

The slot is chosen from the page of the access's last byte. The tag compared is the page of its first byte. An access that crosses a page boundary therefore always misses and falls back to the slow path. Each entry keeps read and write permission as separate per-level bit groups in one permission byte. Entries are loaded through a fill port whose slot is implied by the page frame. An invalidate-all input empties the whole buffer at once.

Top module: `tlb_fastpath`

## Requirements
- R1: While reset is high and in the cycle after it, rsp_valid, rsp_hit, rsp_host_addr, stamp_dec and stamp_ppf are all zero, and every entry is empty.
- R2: rsp_valid and the other results for a request sampled at one rising edge appear after the next rising edge, exactly one cycle later.
- R3: A fill writes the slot given by the low 6 bits of fill_lpf (linear address bits 17:12). A lookup sampled at the same edge as a fill sees the slot's contents from before that fill.
- R4: A lookup hits only if the slot holds a valid entry whose stored page frame equals req_addr[31:12] of the access.
- R5: The slot is taken from bits 17:12 of req_addr + req_len - 1 (req_len from 1 to 8). An access whose bytes span two 4 KiB pages therefore misses, while one ending exactly at offset 0xFFF can hit.
- R6: A read (req_write = 0) is permitted only if bit req_cpl of the entry's permission byte is 1.
- R7: A write (req_write = 1) is permitted only if bit 4 + req_cpl of the permission byte is 1. The read bit has no effect on writes, and the write bit has no effect on reads.
- R8: On a permitted hit, rsp_host_addr equals the stored host base bitwise-ORed with req_addr[11:0].
- R9: A permitted write hit pulses stamp_dec for one cycle with stamp_ppf equal to the entry's physical page frame. A read hit never raises stamp_dec.
- R10: On no request, a miss or a permission failure, rsp_hit is 0, rsp_host_addr is 0, stamp_dec is 0 and stamp_ppf is 0.
- R11: inval_all empties every entry at one edge, so a lookup sampled on the next edge misses. A fill at the same edge as inval_all still takes effect for its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Write one entry this cycle |
| fill_lpf | input | 20 | Linear page frame (tag); low 6 bits select the slot |
| fill_ppf | input | 20 | Physical page frame for the write-stamp strobe |
| fill_host | input | 32 | Host page base |
| fill_perm | input | 8 | Bits 3:0 read enable per level, bits 7:4 write enable per level |
| inval_all | input | 1 | Empty every entry |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Linear address of the first byte |
| req_len | input | 4 | Access length in bytes (1 to 8) |
| req_cpl | input | 2 | Current privilege level |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Result of the request of the previous cycle |
| rsp_hit | output | 1 | Fast path allowed |
| rsp_host_addr | output | 32 | Host address on a hit, else zero |
| stamp_dec | output | 1 | Write-stamp decrement strobe |
| stamp_ppf | output | 20 | Physical page frame for the strobe, else zero |

## Verification
Every lookup result is due exactly one edge after the request is sampled. Fills and invalidations change only lookups sampled on later edges. The bench drives inputs on the falling edge and keeps a behavioural model of the entry array. At each rising edge the model computes the expected outputs from its state before that edge, and then applies the fill and invalidate. The following falling edge compares the outputs with that prediction, which lines up with the one register stage. Directed checks read the ports at the falling edge right after their request's rising edge, including the case of a fill and a lookup at the same edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // permission byte layout: read group in the low nibble, write group above it
  localparam int PERM_W     = 8;
  localparam int CPL_LEVELS = 4;
  localparam int CPL_W      = 2;
  localparam int WR_GRP_LSB = 4;
endpackage

// File: rtl/tlb_index.sv
module tlb_index #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 6,
  parameter int LEN_W     = 4,
  localparam int LPF_W    = ADDR_W - PAGE_BITS
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LEN_W-1:0]     len,
  output logic [IDX_W-1:0]     idx,
  output logic [LPF_W-1:0]     lpf,
  output logic [PAGE_BITS-1:0] off
);
  localparam int EW = PAGE_BITS + 1;
  localparam logic [EW-1:0] PAGE_SIZE = EW'(1) << PAGE_BITS;

  logic [EW-1:0] end_excl;
  logic          spill;

  assign lpf      = addr[ADDR_W-1:PAGE_BITS];
  assign off      = addr[PAGE_BITS-1:0];
  // one past the last byte, measured from the page start
  assign end_excl = {1'b0, off} + EW'(len);
  assign spill    = end_excl > PAGE_SIZE;
  // slot of the last byte: start page plus one if the access spills over
  assign idx      = addr[PAGE_BITS +: IDX_W] + IDX_W'(spill);
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [PERM_W-1:0] perm,
  input  logic [CPL_W-1:0]  cpl,
  input  logic              is_write,
  output logic              allow
);
  logic [CPL_LEVELS-1:0] rd_grp;
  logic [CPL_LEVELS-1:0] wr_grp;

  assign rd_grp = perm[0 +: CPL_LEVELS];
  assign wr_grp = perm[WR_GRP_LSB +: CPL_LEVELS];
  assign allow  = is_write ? wr_grp[cpl] : rd_grp[cpl];
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int IDX_W  = 6,
  parameter int LPF_W  = 20,
  parameter int PPF_W  = 20,
  parameter int HOST_W = 32,
  parameter int PERM_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LPF_W-1:0]  wr_lpf,
  input  logic [PPF_W-1:0]  wr_ppf,
  input  logic [HOST_W-1:0] wr_host,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              inval,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [LPF_W-1:0]  rd_lpf,
  output logic [PPF_W-1:0]  rd_ppf,
  output logic [HOST_W-1:0] rd_host,
  output logic [PERM_W-1:0] rd_perm
);
  logic [LPF_W-1:0]  lpf_mem  [DEPTH];
  logic [PPF_W-1:0]  ppf_mem  [DEPTH];
  logic [HOST_W-1:0] host_mem [DEPTH];
  logic [PERM_W-1:0] perm_mem [DEPTH];
  logic [DEPTH-1:0]  valid_q;

  // payload arrays: no reset so they map onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      lpf_mem[wr_idx]  <= wr_lpf;
      ppf_mem[wr_idx]  <= wr_ppf;
      host_mem[wr_idx] <= wr_host;
      perm_mem[wr_idx] <= wr_perm;
    end
  end

  // tag-valid flags in flops so a flash clear costs one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (inval) valid_q <= '0;
      if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_lpf   = lpf_mem[rd_idx];
  assign rd_ppf   = ppf_mem[rd_idx];
  assign rd_host  = host_mem[rd_idx];
  assign rd_perm  = perm_mem[rd_idx];
endmodule

// File: rtl/tlb_fastpath.sv
module tlb_fastpath
  import tlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 6,
  parameter int LEN_W     = 4,
  parameter int PPF_W     = 20,
  parameter int HOST_W    = 32,
  localparam int LPF_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [LPF_W-1:0]  fill_lpf,
  input  logic [PPF_W-1:0]  fill_ppf,
  input  logic [HOST_W-1:0] fill_host,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inval_all,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [CPL_W-1:0]  req_cpl,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [HOST_W-1:0] rsp_host_addr,
  output logic              stamp_dec,
  output logic [PPF_W-1:0]  stamp_ppf
);
  logic [IDX_W-1:0]     look_idx;
  logic [LPF_W-1:0]     look_lpf;
  logic [PAGE_BITS-1:0] look_off;
  logic                 ent_valid;
  logic [LPF_W-1:0]     ent_lpf;
  logic [PPF_W-1:0]     ent_ppf;
  logic [HOST_W-1:0]    ent_host;
  logic [PERM_W-1:0]    ent_perm;
  logic                 perm_ok;
  logic                 look_hit;

  tlb_index #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_index (
    .addr(req_addr), .len(req_len), .idx(look_idx), .lpf(look_lpf), .off(look_off)
  );

  tlb_store #(
    .IDX_W(IDX_W), .LPF_W(LPF_W), .PPF_W(PPF_W), .HOST_W(HOST_W), .PERM_W(PERM_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(fill_en), .wr_idx(fill_lpf[IDX_W-1:0]), .wr_lpf(fill_lpf),
    .wr_ppf(fill_ppf), .wr_host(fill_host), .wr_perm(fill_perm),
    .inval(inval_all), .rd_idx(look_idx),
    .rd_valid(ent_valid), .rd_lpf(ent_lpf), .rd_ppf(ent_ppf),
    .rd_host(ent_host), .rd_perm(ent_perm)
  );

  tlb_perm u_perm (
    .perm(ent_perm), .cpl(req_cpl), .is_write(req_write), .allow(perm_ok)
  );

  assign look_hit = req_valid && ent_valid && (ent_lpf == look_lpf) && perm_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_host_addr <= '0;
      stamp_dec     <= 1'b0;
      stamp_ppf     <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_hit       <= look_hit;
      rsp_host_addr <= look_hit ? (ent_host | HOST_W'(look_off)) : '0;
      stamp_dec     <= look_hit && req_write;
      stamp_ppf     <= (look_hit && req_write) ? ent_ppf : '0;
    end
  end
endmodule

// File: rtl/tlb_fastpath_chk.sv
module tlb_fastpath_chk #(
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 4,
  parameter int PPF_W     = 20,
  parameter int HOST_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [PAGE_BITS-1:0] req_off,
  input logic [LEN_W-1:0]     req_len,
  input logic                 fill_en,
  input logic                 inval_all,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [HOST_W-1:0]    rsp_host_addr,
  input logic                 stamp_dec,
  input logic [PPF_W-1:0]     stamp_ppf
);
  logic [PAGE_BITS:0] last_byte;
  logic               crosses;
  assign last_byte = {1'b0, req_off} + (PAGE_BITS+1)'(req_len) - (PAGE_BITS+1)'(1);
  assign crosses   = last_byte[PAGE_BITS] && (req_len != '0);

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rsp_valid == $past(req_valid));

  assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  assert_cross_miss_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && crosses) |=> !rsp_hit);

  assert_strobe_on_hit_R9: assert property (@(posedge clk) disable iff (rst)
    stamp_dec |-> rsp_hit);

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_host_addr == '0 && !stamp_dec));

  assert_ppf_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !stamp_dec |-> stamp_ppf == '0);

  assert_flush_R11: assert property (@(posedge clk) disable iff (rst)
    (inval_all && !fill_en) |=> (req_valid |=> !rsp_hit));
endmodule

bind tlb_fastpath tlb_fastpath_chk #(
  .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W), .PPF_W(PPF_W), .HOST_W(HOST_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_off(req_addr[PAGE_BITS-1:0]),
  .req_len(req_len), .fill_en(fill_en), .inval_all(inval_all),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_host_addr(rsp_host_addr),
  .stamp_dec(stamp_dec), .stamp_ppf(stamp_ppf)
);

// File: tb/sim_tlb_fastpath.sv
module sim_tlb_fastpath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fill_en = 1'b0;
  logic [19:0] fill_lpf = '0;
  logic [19:0] fill_ppf = '0;
  logic [31:0] fill_host = '0;
  logic [7:0]  fill_perm = '0;
  logic        inval_all = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = 4'd1;
  logic [1:0]  req_cpl = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_hit, stamp_dec;
  logic [31:0] rsp_host_addr;
  logic [19:0] stamp_ppf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tlb_fastpath u0 (
    .clk(clk), .rst(rst), .fill_en(fill_en), .fill_lpf(fill_lpf), .fill_ppf(fill_ppf),
    .fill_host(fill_host), .fill_perm(fill_perm), .inval_all(inval_all),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_cpl(req_cpl),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_host_addr(rsp_host_addr), .stamp_dec(stamp_dec), .stamp_ppf(stamp_ppf)
  );

  // behavioural reference: plain arrays indexed by slot number
  bit          m_v    [64];
  logic [19:0] m_lpf  [64];
  logic [19:0] m_ppf  [64];
  logic [31:0] m_host [64];
  logic [7:0]  m_perm [64];
  logic        e_valid = 0, e_hit = 0, e_dec = 0;
  logic [31:0] e_host = 0;
  logic [19:0] e_ppf = 0;
  bit          model_on = 0;

  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0; e_hit = 0; e_dec = 0; e_host = 0; e_ppf = 0;
      for (int i = 0; i < 64; i++) m_v[i] = 0;
    end else begin
      logic [31:0] last;
      int s;
      bit ok;
      last = req_addr + 32'(req_len) - 32'd1;
      s = int'(last[17:12]);
      ok = req_write ? m_perm[s][4 + int'(req_cpl)] : m_perm[s][int'(req_cpl)];
      e_valid = req_valid;
      e_hit = req_valid && m_v[s] && (m_lpf[s] == req_addr[31:12]) && ok;
      e_host = e_hit ? (m_host[s] | {20'd0, req_addr[11:0]}) : 32'd0;
      e_dec = e_hit && req_write;
      e_ppf = e_dec ? m_ppf[s] : 20'd0;
      if (inval_all) for (int i = 0; i < 64; i++) m_v[i] = 0;
      if (fill_en) begin
        s = int'(fill_lpf[5:0]);
        m_v[s] = 1; m_lpf[s] = fill_lpf; m_ppf[s] = fill_ppf;
        m_host[s] = fill_host; m_perm[s] = fill_perm;
      end
    end
    model_on = 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk("R2 model rsp_valid", 64'(rsp_valid), 64'(e_valid));
      chk("R4 model rsp_hit", 64'(rsp_hit), 64'(e_hit));
      chk("R8 model rsp_host_addr", 64'(rsp_host_addr), 64'(e_host));
      chk("R9 model stamp_dec", 64'(stamp_dec), 64'(e_dec));
      chk("R9 model stamp_ppf", 64'(stamp_ppf), 64'(e_ppf));
    end
  end

  task automatic fill(input logic [19:0] lpf, input logic [19:0] ppf,
                      input logic [31:0] host, input logic [7:0] perm);
    @(negedge clk);
    fill_en = 1; fill_lpf = lpf; fill_ppf = ppf; fill_host = host; fill_perm = perm;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(input logic [31:0] a, input logic [3:0] l,
                      input logic [1:0] c, input logic w);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_len = l; req_cpl = c; req_write = w;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", 64'(rsp_valid), 0);
    chk("R1 reset rsp_hit", 64'(rsp_hit), 0);
    chk("R1 reset host", 64'(rsp_host_addr), 0);
    chk("R1 reset stamp", 64'({stamp_dec, stamp_ppf}), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset rsp_valid", 64'(rsp_valid), 0);
    look(32'h12345010, 4'd4, 2'd0, 1'b0);
    chk("R1 empty after reset", 64'(rsp_hit), 0);

    // entry A: read at levels 0 and 1 only
    fill(20'h12345, 20'hABCDE, 32'h80000000, 8'h03);
    look(32'h12345010, 4'd4, 2'd0, 1'b0);
    chk("R6 read cpl0 hit", 64'(rsp_hit), 1);
    chk("R2 rsp_valid with request", 64'(rsp_valid), 1);
    chk("R8 host compose", 64'(rsp_host_addr), 64'h80000010);
    chk("R9 read gives no strobe", 64'(stamp_dec), 0);
    look(32'h12345010, 4'd4, 2'd2, 1'b0);
    chk("R6 read cpl2 denied", 64'(rsp_hit), 0);
    chk("R10 denied host zero", 64'(rsp_host_addr), 0);
    look(32'h12345010, 4'd4, 2'd0, 1'b1);
    chk("R7 write without write bit", 64'(rsp_hit), 0);
    chk("R10 denied no strobe", 64'({stamp_dec, stamp_ppf}), 0);

    // entry B: write at levels 0 and 1 only, host base has low bits set
    fill(20'h00042, 20'h00777, 32'h40000005, 8'h30);
    look(32'h00042FF0, 4'd8, 2'd1, 1'b1);
    chk("R7 write cpl1 hit", 64'(rsp_hit), 1);
    chk("R8 OR compose", 64'(rsp_host_addr), 64'h40000FF5);
    chk("R9 strobe", 64'(stamp_dec), 1);
    chk("R9 strobe ppf", 64'(stamp_ppf), 64'h00777);
    @(negedge clk);
    chk("R9 strobe lasts one cycle", 64'(stamp_dec), 0);
    look(32'h00042FF0, 4'd8, 2'd0, 1'b0);
    chk("R7 read bit clear denies read", 64'(rsp_hit), 0);

    // page crossing
    fill(20'h00043, 20'h00888, 32'h50000000, 8'hFF);
    look(32'h00042FFC, 4'd8, 2'd0, 1'b1);
    chk("R5 crossing access misses", 64'(rsp_hit), 0);
    look(32'h00042FFC, 4'd4, 2'd0, 1'b1);
    chk("R5 ending at 0xFFF hits", 64'(rsp_hit), 1);
    look(32'h00043000, 4'd1, 2'd3, 1'b0);
    chk("R3 slot 3 holds its own page", 64'(rsp_host_addr), 64'h50000000);

    // tag mismatch in the same slot
    look(32'h40042010, 4'd2, 2'd0, 1'b1);
    chk("R4 tag mismatch misses", 64'(rsp_hit), 0);

    // fill and lookup at the same edge
    @(negedge clk);
    fill_en = 1; fill_lpf = 20'h00050; fill_ppf = 20'h1; fill_host = 32'h60000000;
    fill_perm = 8'h0F;
    req_valid = 1; req_addr = 32'h00050100; req_len = 4'd1; req_cpl = 2'd3; req_write = 0;
    @(negedge clk);
    fill_en = 0;
    chk("R3 same-edge fill not seen", 64'(rsp_hit), 0);
    @(negedge clk);
    req_valid = 0;
    chk("R3 fill seen next edge", 64'(rsp_hit), 1);

    // flush, and flush together with a fill
    @(negedge clk);
    inval_all = 1;
    @(negedge clk);
    inval_all = 0;
    look(32'h12345010, 4'd4, 2'd0, 1'b0);
    chk("R11 flush empties entry A", 64'(rsp_hit), 0);
    look(32'h00050100, 4'd1, 2'd3, 1'b0);
    chk("R11 flush empties filled slot", 64'(rsp_hit), 0);
    @(negedge clk);
    inval_all = 1; fill_en = 1; fill_lpf = 20'h00060; fill_ppf = 20'h2;
    fill_host = 32'h70000000; fill_perm = 8'hFF;
    @(negedge clk);
    inval_all = 0; fill_en = 0;
    look(32'h00060004, 4'd2, 2'd0, 1'b1);
    chk("R11 fill wins over flush", 64'(rsp_hit), 1);
    chk("R11 fill wins ppf", 64'(stamp_ppf), 64'h2);

    // mixed traffic compared against the model every cycle
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      fill_en = ($urandom % 4) == 0;
      fill_lpf = {12'd0, 2'($urandom), 6'($urandom % 8)};
      fill_ppf = 20'($urandom);
      fill_host = {20'($urandom), 12'd0};
      fill_perm = 8'($urandom);
      inval_all = ($urandom % 50) == 0;
      req_valid = ($urandom % 4) != 0;
      req_addr = {12'd0, 2'($urandom), 6'($urandom % 8), 12'($urandom)};
      if (($urandom % 3) == 0) req_addr[11:0] = 12'hFF8 | 12'($urandom % 8);
      req_len = 4'(1 + ($urandom % 8));
      req_cpl = 2'($urandom);
      req_write = 1'($urandom);
    end
    @(negedge clk);
    fill_en = 0; inval_all = 0; req_valid = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule